// File: doc/BRIEF.md
# Windowed Memory Address Translator

This block turns two kinds of processor address into physical memory targets. A 16-bit data address lands in on-chip data RAM, on-chip instruction RAM, or a page of a segmented unified memory. An 18-bit instruction byte address lands in instruction RAM or in a unified segment. Three 16-bit map registers steer the translation: one data map and two instruction maps, one for each half of the instruction space. The data map controls a 16 KiB data window at 0x8000-0xBFFF. The upper data region is I/O space, and only a small legal hole in it is accepted.

The memories are not part of this block, and neither is the allocation of unified segments. A 128-bit presence bitmap tells the block which unified segments exist. A data access to an absent segment raises a bus error. An instruction access to an absent segment raises an unmapped flag.

Each translator has two states, idle and holding a result. The move from idle to holding happens on every cycle with a valid input. The move back to idle happens on every cycle without one. The map register file has no states: it is a plain write-and-read port.

Top module: `win_addr_xlate`

## Requirements
- R1: A data address below 0x8000 yields target code 2'b00 (data RAM) with offset equal to the address, segment 0 and no bus error. Target codes are 2'b00 data RAM, 2'b01 instruction RAM and 2'b10 unified memory.
- R2: A data address of 0xC000 or above yields target 2'b00 with offset equal to the address and segment 0. The bus error is raised unless address bits [15:4] equal 0xFF0.
- R3: A data address in 0x8000-0xBFFF with data-map bit 12 set yields target 2'b01. Its offset is map[3:0]*0x4000 + (addr - 0x8000), its segment is 0 and there is no bus error.
- R4: A data address in 0x8000-0xBFFF with data-map bit 12 clear yields target 2'b10 and segment map[9:3]. Its offset is map[2:0]*0x4000 + (addr - 0x8000). The bus error is raised exactly when presence bit map[9:3] is 0.
- R5: Instruction address bit 17 selects the map: 0 picks instruction map 0 and 1 picks instruction map 1.
- R6: When the selected instruction map has bit 12 set, the result is target 2'b01 with offset equal to the full 18-bit address, segment 0 and no unmapped flag.
- R7: When the selected instruction map has bit 12 clear, the result is target 2'b10 with segment map[7:0] and offset equal to address bits [16:0]. The unmapped flag is raised when the segment is 128 or more, or when its presence bit is 0.
- R8: After reset, instruction map 0 reads 0x0000, instruction map 1 reads 0x007F and the data map reads 0x0000.
- R9: A write with select 0, 1 or 2 loads instruction map 0, instruction map 1 or the data map, in that order. Read data shows the selected map without delay. Select 3 reads 0, and a write to select 3 changes no map.
- R10: Each result and its valid flag appear one clock after the valid input. A translation in the same cycle as a map write uses the map value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Map register write strobe |
| cfg_sel | input | 2 | Map select: 0 imap0, 1 imap1, 2 dmap, 3 none |
| cfg_wdata | input | 16 | Map write data |
| cfg_rdata | output | 16 | Selected map read data |
| seg_present | input | 128 | Presence bit per unified segment |
| d_valid | input | 1 | Data address valid |
| d_addr | input | 16 | Data address |
| d_out_valid | output | 1 | Data result valid |
| d_target | output | 2 | Data target code |
| d_seg | output | 8 | Data unified segment |
| d_offset | output | 18 | Data target offset |
| d_buserr | output | 1 | Data bus error |
| i_valid | input | 1 | Instruction address valid |
| i_addr | input | 18 | Instruction byte address |
| i_out_valid | output | 1 | Instruction result valid |
| i_target | output | 2 | Instruction target code |
| i_seg | output | 8 | Instruction unified segment |
| i_offset | output | 18 | Instruction target offset |
| i_unmapped | output | 1 | Instruction unmapped flag |

## Verification
Translation results are registered, so the result for an address driven before edge N appears after edge N. The bench drives on a falling edge and checks the outputs on the next falling edge, which is exactly one rising edge later. Map read data is combinational. The bench checks it a short delay after changing the select, in the same half cycle. A map write lands on the next rising edge, so the shadow model used for expected values changes only after that edge. The coincident-write test still expects the old map.

// File: rtl/wat_pkg.sv
package wat_pkg;
    typedef enum logic [1:0] {
        TGT_DRAM = 2'b00,
        TGT_IRAM = 2'b01,
        TGT_UMEM = 2'b10
    } tgt_e;

    typedef enum logic [1:0] {
        RG_LOW,
        RG_WIN,
        RG_IO
    } region_e;

    typedef enum logic {
        XS_IDLE,
        XS_HOLD
    } xstate_e;

    localparam int MAP_W        = 16;
    localparam int NUM_MAPS     = 3;
    localparam int MAP_IRAM_BIT = 12;
    localparam logic [MAP_W-1:0] MAP_RST [NUM_MAPS] = '{16'h0000, 16'h007F, 16'h0000};
endpackage

// File: rtl/wat_map_regs.sv
module wat_map_regs
    import wat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [MAP_W-1:0] cfg_wdata,
    output logic [MAP_W-1:0] cfg_rdata,
    output logic [MAP_W-1:0] imap0,
    output logic [MAP_W-1:0] imap1,
    output logic [MAP_W-1:0] dmap
);
    logic [MAP_W-1:0] map_q [NUM_MAPS];

    for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_q[g] <= MAP_RST[g];
            else if (cfg_we && (cfg_sel == 2'(g)))
                map_q[g] <= cfg_wdata;
        end
    end

    always_comb begin
        unique case (cfg_sel)
            2'd0:    cfg_rdata = map_q[0];
            2'd1:    cfg_rdata = map_q[1];
            2'd2:    cfg_rdata = map_q[2];
            default: cfg_rdata = '0;
        endcase
    end

    assign imap0 = map_q[0];
    assign imap1 = map_q[1];
    assign dmap  = map_q[2];

    // R9: data-map write lands on the next edge
    p_dmap_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_sel == 2'd2 |=> dmap == $past(cfg_wdata));
    // R9: select 3 writes leave every map untouched
    p_sel3_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_sel == 2'd3 |=> $stable(imap0) && $stable(imap1) && $stable(dmap));
endmodule

// File: rtl/wat_data_xlate.sv
module wat_data_xlate
    import wat_pkg::*;
#(
    parameter int DADDR_W = 16,
    parameter int IADDR_W = 18,
    parameter int UOFF_W  = 17,
    parameter int WIN_W   = 14,
    parameter int SEG_W   = 7,
    parameter int SEGIX_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   map_to_iram,
    input  logic [UOFF_W-WIN_W+SEG_W-1:0] map_field,
    input  logic [(1<<SEG_W)-1:0]  seg_present,
    input  logic                   d_valid,
    input  logic [DADDR_W-1:0]     d_addr,
    output logic                   d_out_valid,
    output logic [1:0]             d_target,
    output logic [SEGIX_W-1:0]     d_seg,
    output logic [IADDR_W-1:0]     d_offset,
    output logic                   d_buserr
);
    localparam int IPAGE_W = IADDR_W - WIN_W;
    localparam int UPAGE_W = UOFF_W - WIN_W;
    localparam int TAG_W   = DADDR_W - 4;
    localparam logic [TAG_W-1:0] IO_TAG = TAG_W'(12'hFF0);

    region_e              region;
    tgt_e                 tgt_n;
    logic [SEGIX_W-1:0]   seg_n;
    logic [IADDR_W-1:0]   off_n;
    logic                 err_n;
    logic [SEG_W-1:0]     useg;
    xstate_e              st_q;

    assign useg = map_field[UPAGE_W +: SEG_W];

    always_comb begin
        if (!d_addr[DADDR_W-1])      region = RG_LOW;
        else if (!d_addr[DADDR_W-2]) region = RG_WIN;
        else                         region = RG_IO;
    end

    always_comb begin
        tgt_n = TGT_DRAM;
        seg_n = '0;
        off_n = IADDR_W'(d_addr);
        err_n = 1'b0;
        unique case (region)
            RG_LOW: ;
            RG_IO:  err_n = (d_addr[DADDR_W-1:4] != IO_TAG);
            RG_WIN: begin
                if (map_to_iram) begin
                    tgt_n = TGT_IRAM;
                    off_n = {map_field[IPAGE_W-1:0], d_addr[WIN_W-1:0]};
                end else begin
                    tgt_n = TGT_UMEM;
                    seg_n = SEGIX_W'(useg);
                    off_n = IADDR_W'({map_field[UPAGE_W-1:0], d_addr[WIN_W-1:0]});
                    err_n = !seg_present[useg];
                end
            end
            default: ;
        endcase
    end

    // result register (IDLE <-> HOLD follows d_valid)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= XS_IDLE;
            d_target <= TGT_DRAM;
            d_seg    <= '0;
            d_offset <= '0;
            d_buserr <= 1'b0;
        end else begin
            st_q <= d_valid ? XS_HOLD : XS_IDLE;
            if (d_valid) begin
                d_target <= tgt_n;
                d_seg    <= seg_n;
                d_offset <= off_n;
                d_buserr <= err_n;
            end
        end
    end

    assign d_out_valid = (st_q == XS_HOLD);

    // R1: lower half goes straight to data RAM
    p_low_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid && !d_addr[DADDR_W-1] |=>
            d_target == TGT_DRAM && !d_buserr && d_offset == IADDR_W'($past(d_addr)));
    // R2: outside the legal I/O hole the bus error rises
    p_io_hole_r2: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid && d_addr[DADDR_W-1 -: 2] == 2'b11 && d_addr[DADDR_W-1:4] != IO_TAG |=> d_buserr);
    // R10: result valid one cycle after request
    p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |=> d_out_valid);
    p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !d_valid |=> !d_out_valid);
endmodule

// File: rtl/wat_inst_xlate.sv
module wat_inst_xlate
    import wat_pkg::*;
#(
    parameter int IADDR_W = 18,
    parameter int UOFF_W  = 17,
    parameter int SEG_W   = 7,
    parameter int SEGIX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  m0_iram,
    input  logic [SEGIX_W-1:0]    m0_seg,
    input  logic                  m1_iram,
    input  logic [SEGIX_W-1:0]    m1_seg,
    input  logic [(1<<SEG_W)-1:0] seg_present,
    input  logic                  i_valid,
    input  logic [IADDR_W-1:0]    i_addr,
    output logic                  i_out_valid,
    output logic [1:0]            i_target,
    output logic [SEGIX_W-1:0]    i_seg,
    output logic [IADDR_W-1:0]    i_offset,
    output logic                  i_unmapped
);
    localparam int NSEG = 1 << SEG_W;

    logic               hi_half;
    logic               sel_iram;
    logic [SEGIX_W-1:0] sel_seg;
    tgt_e               tgt_n;
    logic [SEGIX_W-1:0] seg_n;
    logic [IADDR_W-1:0] off_n;
    logic               unm_n;
    xstate_e            st_q;

    assign hi_half  = i_addr[IADDR_W-1];
    assign sel_iram = hi_half ? m1_iram : m0_iram;
    assign sel_seg  = hi_half ? m1_seg  : m0_seg;

    always_comb begin
        if (sel_iram) begin
            tgt_n = TGT_IRAM;
            seg_n = '0;
            off_n = i_addr;
            unm_n = 1'b0;
        end else begin
            tgt_n = TGT_UMEM;
            seg_n = sel_seg;
            off_n = IADDR_W'(i_addr[UOFF_W-1:0]);
            unm_n = (sel_seg > SEGIX_W'(NSEG - 1)) || !seg_present[sel_seg[SEG_W-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= XS_IDLE;
            i_target   <= TGT_DRAM;
            i_seg      <= '0;
            i_offset   <= '0;
            i_unmapped <= 1'b0;
        end else begin
            st_q <= i_valid ? XS_HOLD : XS_IDLE;
            if (i_valid) begin
                i_target   <= tgt_n;
                i_seg      <= seg_n;
                i_offset   <= off_n;
                i_unmapped <= unm_n;
            end
        end
    end

    assign i_out_valid = (st_q == XS_HOLD);

    // R6: lower half with map 0 pointing at instruction RAM keeps the full address
    p_iram_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid && !i_addr[IADDR_W-1] && m0_iram |=>
            i_target == TGT_IRAM && i_offset == $past(i_addr) && !i_unmapped);
    // R7: a segment index past the last segment is unmapped
    p_big_seg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid && i_addr[IADDR_W-1] && !m1_iram && m1_seg[SEGIX_W-1] |=> i_unmapped);
    // R10: result valid one cycle after request
    p_ivalid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid |=> i_out_valid);
endmodule

// File: rtl/win_addr_xlate.sv
module win_addr_xlate
    import wat_pkg::*;
#(
    parameter int DADDR_W = 16,
    parameter int IADDR_W = 18,
    parameter int UOFF_W  = 17,
    parameter int WIN_W   = 14,
    parameter int SEG_W   = 7,
    parameter int SEGIX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [15:0]           cfg_wdata,
    output logic [15:0]           cfg_rdata,
    input  logic [(1<<SEG_W)-1:0] seg_present,
    input  logic                  d_valid,
    input  logic [DADDR_W-1:0]    d_addr,
    output logic                  d_out_valid,
    output logic [1:0]            d_target,
    output logic [SEGIX_W-1:0]    d_seg,
    output logic [IADDR_W-1:0]    d_offset,
    output logic                  d_buserr,
    input  logic                  i_valid,
    input  logic [IADDR_W-1:0]    i_addr,
    output logic                  i_out_valid,
    output logic [1:0]            i_target,
    output logic [SEGIX_W-1:0]    i_seg,
    output logic [IADDR_W-1:0]    i_offset,
    output logic                  i_unmapped
);
    localparam int DFIELD_W = UOFF_W - WIN_W + SEG_W;

    logic [MAP_W-1:0] imap0, imap1, dmap;

    wat_map_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .imap0     (imap0),
        .imap1     (imap1),
        .dmap      (dmap)
    );

    wat_data_xlate #(
        .DADDR_W (DADDR_W), .IADDR_W (IADDR_W), .UOFF_W (UOFF_W),
        .WIN_W   (WIN_W),   .SEG_W   (SEG_W),   .SEGIX_W (SEGIX_W)
    ) u_data (
        .clk         (clk),
        .rst_n       (rst_n),
        .map_to_iram (dmap[MAP_IRAM_BIT]),
        .map_field   (dmap[DFIELD_W-1:0]),
        .seg_present (seg_present),
        .d_valid     (d_valid),
        .d_addr      (d_addr),
        .d_out_valid (d_out_valid),
        .d_target    (d_target),
        .d_seg       (d_seg),
        .d_offset    (d_offset),
        .d_buserr    (d_buserr)
    );

    wat_inst_xlate #(
        .IADDR_W (IADDR_W), .UOFF_W (UOFF_W), .SEG_W (SEG_W), .SEGIX_W (SEGIX_W)
    ) u_inst (
        .clk         (clk),
        .rst_n       (rst_n),
        .m0_iram     (imap0[MAP_IRAM_BIT]),
        .m0_seg      (imap0[SEGIX_W-1:0]),
        .m1_iram     (imap1[MAP_IRAM_BIT]),
        .m1_seg      (imap1[SEGIX_W-1:0]),
        .seg_present (seg_present),
        .i_valid     (i_valid),
        .i_addr      (i_addr),
        .i_out_valid (i_out_valid),
        .i_target    (i_target),
        .i_seg       (i_seg),
        .i_offset    (i_offset),
        .i_unmapped  (i_unmapped)
    );
endmodule

// File: tb/sim_win_addr_xlate.sv
`timescale 1ns/1ps
module sim_win_addr_xlate;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_sel = 2'd0;
    logic [15:0]  cfg_wdata = 16'h0;
    logic [15:0]  cfg_rdata;
    logic [127:0] seg_present;
    logic         d_valid = 1'b0;
    logic [15:0]  d_addr = 16'h0;
    logic         d_out_valid;
    logic [1:0]   d_target;
    logic [7:0]   d_seg;
    logic [17:0]  d_offset;
    logic         d_buserr;
    logic         i_valid = 1'b0;
    logic [17:0]  i_addr = 18'h0;
    logic         i_out_valid;
    logic [1:0]   i_target;
    logic [7:0]   i_seg;
    logic [17:0]  i_offset;
    logic         i_unmapped;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    logic [15:0] sh_i0, sh_i1, sh_d;

    always #4 clk = ~clk;

    win_addr_xlate u0 (.*);

    function automatic bit pres(int k);
        return (k % 3) != 1;
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wr_map(logic [1:0] sel, logic [15:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0: sh_i0 = val;
            2'd1: sh_i1 = val;
            2'd2: sh_d  = val;
            default: ;
        endcase
    endtask

    task automatic exp_d(input logic [15:0] a, input logic [15:0] m,
                         output logic [1:0] t, output logic [7:0] s,
                         output logic [17:0] o, output logic e, output string tag);
        s = 0; o = 18'(a); e = 0; t = 2'b00;
        if (a < 16'h8000) tag = "R1";
        else if (a > 16'hBFFF) begin
            tag = "R2";
            e = (a[15:4] != 12'hFF0);
        end else if (m[12]) begin
            tag = "R3"; t = 2'b01;
            o = 18'(m[3:0]) * 18'h4000 + 18'(a - 16'h8000);
        end else begin
            tag = "R4"; t = 2'b10;
            s = 8'((m >> 3) & 16'h7F);
            o = 18'(m[2:0]) * 18'h4000 + 18'(a - 16'h8000);
            e = !pres(int'(s));
        end
    endtask

    task automatic chk_d(logic [15:0] a);
        logic [1:0] t; logic [7:0] s; logic [17:0] o; logic e; string tag;
        exp_d(a, sh_d, t, s, o, e, tag);
        d_valid = 1'b1; d_addr = a;
        @(negedge clk);
        d_valid = 1'b0;
        chk(d_out_valid && d_target == t && d_seg == s && d_offset == o && d_buserr == e,
            tag, $sformatf("d_addr=%h {v,tgt,seg,off,err}", a),
            {d_out_valid, d_target, d_seg, d_offset, d_buserr}, {1'b1, t, s, o, e});
    endtask

    task automatic chk_i(logic [17:0] a);
        logic [15:0] m; logic [1:0] t; logic [7:0] s; logic [17:0] o; logic u; string tag;
        m = a[17] ? sh_i1 : sh_i0;
        if (m[12]) begin
            tag = "R6"; t = 2'b01; s = 0; o = a; u = 0;
        end else begin
            tag = "R7"; t = 2'b10; s = m[7:0]; o = a & 18'h1FFFF;
            u = (s >= 8'd128) || !pres(int'(s));
        end
        i_valid = 1'b1; i_addr = a;
        @(negedge clk);
        i_valid = 1'b0;
        chk(i_out_valid && i_target == t && i_seg == s && i_offset == o && i_unmapped == u,
            tag, $sformatf("R5 i_addr=%h {v,tgt,seg,off,unm}", a),
            {i_out_valid, i_target, i_seg, i_offset, i_unmapped}, {1'b1, t, s, o, u});
    endtask

    task automatic chk_rd(logic [1:0] sel, logic [15:0] exp, string tag);
        cfg_sel = sel;
        #1;
        chk(cfg_rdata == exp, tag, $sformatf("readback sel=%0d", sel), cfg_rdata, exp);
    endtask

    initial begin
        for (int k = 0; k < 128; k++) seg_present[k] = pres(k);
        sh_i0 = 16'h0000; sh_i1 = 16'h007F; sh_d = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset values, R10 idle valid flags
        chk_rd(2'd0, 16'h0000, "R8");
        chk_rd(2'd1, 16'h007F, "R8");
        chk_rd(2'd2, 16'h0000, "R8");
        chk_rd(2'd3, 16'h0000, "R9");
        chk(!d_out_valid && !i_out_valid, "R10", "idle valid flags", {d_out_valid, i_out_valid}, 0);

        // R9 writes and readback; select 3 ignored
        @(negedge clk);
        wr_map(2'd0, 16'hA5C3); wr_map(2'd1, 16'h1234); wr_map(2'd2, 16'h5A3C);
        chk_rd(2'd0, 16'hA5C3, "R9");
        chk_rd(2'd1, 16'h1234, "R9");
        chk_rd(2'd2, 16'h5A3C, "R9");
        @(negedge clk);
        wr_map(2'd3, 16'hFFFF);
        chk_rd(2'd0, 16'hA5C3, "R9");
        chk_rd(2'd1, 16'h1234, "R9");
        chk_rd(2'd2, 16'h5A3C, "R9");
        chk_rd(2'd3, 16'h0000, "R9");
        @(negedge clk);

        // R1/R2 strided sweep plus full I/O tail, under three data maps
        foreach (sh_i0[j]) ;
        for (int mi = 0; mi < 3; mi++) begin
            wr_map(2'd2, (mi == 0) ? 16'h0000 : (mi == 1) ? 16'h100B : 16'h03FF);
            for (int a = 0; a < 65536; a += 53) chk_d(16'(a));
            chk_d(16'h7FFF); chk_d(16'h8000); chk_d(16'hBFFF); chk_d(16'hC000);
        end
        for (int a = 16'hFE00; a <= 16'hFFFF; a++) chk_d(16'(a));

        // R3/R4 sweep over data-map fields
        for (int m = 0; m < 2048; m++) begin
            wr_map(2'd2, 16'((m & 1023) | ((m >> 10) << 12) | ((m & 7) << 13)));
            chk_d(16'h8000); chk_d(16'hBFFF); chk_d(16'(16'h8000 + (m * 7 & 16'h3FFF)));
        end

        // R5/R6/R7 sweep over instruction maps
        for (int m = 0; m < 512; m++) begin
            wr_map(2'd0, 16'((m & 255) | ((m >> 8) << 12)));
            wr_map(2'd1, 16'(((m + 37) & 255) | (((m >> 8) ^ 1) << 12) | 16'h0100));
            chk_i(18'h00000); chk_i(18'h1FFFF); chk_i(18'h20000); chk_i(18'h3FFFF);
            chk_i(18'((m * 613) & 18'h3FFFF));
        end

        // R10 coincident write uses the old map
        wr_map(2'd2, 16'h0011);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 16'h1003;
        begin
            logic [1:0] t; logic [7:0] s; logic [17:0] o; logic e; string tag;
            exp_d(16'h8123, 16'h0011, t, s, o, e, tag);
            d_valid = 1'b1; d_addr = 16'h8123;
            @(negedge clk);
            cfg_we = 1'b0; d_valid = 1'b0; sh_d = 16'h1003;
            chk(d_target == t && d_offset == o && d_seg == s, "R10", "old map on coincident write",
                {d_target, d_seg, d_offset}, {t, s, o});
        end
        chk_d(16'h8123);
        @(negedge clk);
        chk(!d_out_valid, "R10", "valid drops", d_out_valid, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule